// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filtering

This block is the receive half of an asynchronous serial port that carries 11-bit frames. Each frame has one low start bit, eight data bits sent least significant bit first, a ninth data bit and a high stop bit. The serial line first passes through a two-flop synchronizer. While the receiver is idle it watches the synchronized line for a high-to-low edge. It then times each bit with a clock enable that pulses sixteen times per bit, and it samples every bit once, in the middle of the bit.

When the ninth bit has been sampled, the block decides at once whether to keep the frame. The frame is kept only if the receive-complete flag is clear and either multiprocessor filtering is off or the ninth bit is 1. Any other frame is dropped without a trace. In a multidrop system the ninth bit marks address frames. A node that sets the filter input ignores data frames until it recognises its own address. Software clears the receive-complete flag with a one-cycle pulse.

Top module: `uart9_rx`

## Requirements
- R1: After reset `ri` = 0, `rx_data` = 0x00 and `rb8` = 0.
- R2: While `rx_en` = 1 and the receiver is idle, a high-to-low transition on the synchronized `rxd` starts a frame. The line passes through two flops before edge detection.
- R3: The start bit is re-sampled on the 8th `tick16` after the edge. If the line is high at that point, the receiver drops the attempt and goes back to idle. No flag or register changes.
- R4: Data bits are sampled once every 16 ticks after the start sample, least significant bit first. Sample 1 is data bit 0, sample 8 is data bit 7 and sample 9 is the ninth bit.
- R5: On the ninth sample, the frame is committed if `ri` = 0 and either `sm2` = 0 or the ninth bit = 1. On commit, the eight data bits go to `rx_data`, the ninth bit goes to `rb8`, and `ri` reads 1 from the next cycle.
- R6: A frame whose ninth sample finds `ri` = 1 is discarded. `rx_data`, `rb8` and `ri` keep their values.
- R7: With `sm2` = 1, a frame whose ninth bit is 0 is discarded. `ri`, `rx_data` and `rb8` are unchanged.
- R8: `ri` falls only on a one-cycle `ri_clr` pulse, and it reads 0 in the next cycle. A commit in the same cycle takes precedence.
- R9: 16 ticks after the ninth sample, the receiver goes back to hunting for a start edge, whether or not the frame was kept. A frame that starts right after the stop bit is therefore received.
- R10: While `rx_en` = 0, the receiver stays idle, and a frame in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, sixteen pulses per bit time |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rx_en | input | 1 | Receiver enable |
| sm2 | input | 1 | Multiprocessor filtering: keep only frames whose ninth bit is 1 |
| ri_clr | input | 1 | One-cycle pulse that clears the receive-complete flag |
| rx_data | output | 8 | Last committed eight data bits |
| rb8 | output | 1 | Last committed ninth bit |
| ri | output | 1 | Receive-complete flag |

## Verification
A bit counter or tick counter that is off by one shifts every sample by a bit. It shows up as a wrong `rx_data` or `rb8` on the first committed frame, at most one frame time after the fault. A state machine that is stuck outside idle makes the receiver drop the next frame, which a back-to-back pair exposes within two frames. A wrong commit decision makes `ri` rise, or fail to rise, at the end of a filtered or blocked frame. A missed false-start abort shows as spurious data within one frame of the glitch.

// File: rtl/uart9_pkg.sv
// Package: shared types for the nine-bit serial receiver.
// Assumes: one start bit, eight data bits, ninth bit, one stop bit.
package uart9_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/uart9_sync.sv
// Module: uart9_sync
// Brings the asynchronous line into the clock domain through two flops
// and flags a high-to-low change of the synchronized level.
// Assumes: line idles high; reset value is high so reset makes no edge.
module uart9_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_in};
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign line_s = chain[STAGES-1];
    assign fall   = prev & ~chain[STAGES-1];

    assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> !line_s && $past(line_s));
endmodule

// File: rtl/uart9_framer.sv
// Module: uart9_framer
// Times the start, data and stop bits with the oversampling enable and
// shifts in the nine data bits LSB first. It pulses final_shift with
// the complete nine-bit word on the cycle of the last sample.
// Assumes: tick is a single-cycle enable, OVERSAMPLE ticks per bit.
module uart9_framer
    import uart9_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int NBITS      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic             line_s,
    input  logic             fall,
    output logic             final_shift,
    output logic [NBITS-1:0] word
);
    localparam int CW  = $clog2(OVERSAMPLE);
    localparam int BW  = $clog2(NBITS + 1);
    localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);
    localparam logic [BW-1:0] TOPB = BW'(NBITS - 1);

    rx_state_t        state;
    logic [CW-1:0]    cnt;
    logic [BW-1:0]    bit_idx;
    logic [NBITS-1:0] shreg;
    logic             sample_now;

    assign sample_now  = (state == ST_DATA) && tick && (cnt == LAST);
    assign final_shift = sample_now && (bit_idx == TOPB);
    assign word        = {line_s, shreg[NBITS-1:1]};

    // Bit-timing state machine with tick counter and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt     <= '0;
                    bit_idx <= '0;
                    if (fall) state <= ST_START;
                end
                ST_START: if (tick) begin
                    if (cnt == MID) begin
                        cnt   <= '0;
                        state <= line_s ? ST_IDLE : ST_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        cnt <= '0;
                        if (bit_idx == TOPB) state <= ST_STOP;
                        else                 bit_idx <= bit_idx + 1'b1;
                    end
                end
                ST_STOP: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Shift each mid-bit sample in at the top so bit 0 ends at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)          shreg <= '0;
        else if (sample_now) shreg <= word;
    end

    assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state == ST_IDLE);
    assert_bit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= TOPB);
    assert_stop_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        final_shift && enable |=> state == ST_STOP);
    assert_false_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) && tick && (cnt == MID) && line_s && enable
        |=> state == ST_IDLE);
endmodule

// File: rtl/uart9_commit.sv
// Module: uart9_commit
// Decides at the final sample whether a frame is kept, and holds the
// receive buffer, ninth-bit register and receive-complete flag.
// Assumes: final_shift is a one-cycle pulse with the word valid with it.
module uart9_commit #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              final_shift,
    input  logic [DATA_W:0]   word,
    input  logic              filter_on,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] buf_q,
    output logic              ninth_q,
    output logic              flag_q
);
    logic accept;

    assign accept = final_shift && !flag_q && (!filter_on || word[DATA_W]);

    // Load buffer and ninth bit only on an accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q   <= '0;
            ninth_q <= 1'b0;
        end else if (accept) begin
            buf_q   <= word[DATA_W-1:0];
            ninth_q <= word[DATA_W];
        end
    end

    // Receive-complete flag: set on accept, else cleared by the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (accept)   flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assert_data_only_on_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(buf_q) |-> flag_q && !$past(flag_q));
    assert_set_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(final_shift) && (!$past(filter_on) || ninth_q));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !final_shift |=> !flag_q);
    assert_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
        final_shift && filter_on && !word[DATA_W] |=> $stable(buf_q) && $stable(ninth_q));
endmodule

// File: rtl/uart9_rx.sv
// Module: uart9_rx (top)
// Nine-bit asynchronous receiver with multiprocessor address filtering.
// Assumes: tick16 pulses OVERSAMPLE times per bit, synchronous reset.
module uart9_rx #(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              sm2,
    input  logic              ri_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rb8,
    output logic              ri
);
    localparam int NBITS = DATA_W + 1;

    logic             line_s;
    logic             fall;
    logic             final_shift;
    logic [NBITS-1:0] word;

    uart9_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(rxd), .line_s(line_s), .fall(fall)
    );

    uart9_framer #(.OVERSAMPLE(OVERSAMPLE), .NBITS(NBITS)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .enable(rx_en),
        .line_s(line_s), .fall(fall), .final_shift(final_shift), .word(word)
    );

    uart9_commit #(.DATA_W(DATA_W)) u_commit (
        .clk(clk), .rst_n(rst_n), .final_shift(final_shift), .word(word),
        .filter_on(sm2), .flag_clr(ri_clr),
        .buf_q(rx_data), .ninth_q(rb8), .flag_q(ri)
    );
endmodule

// File: tb/sim_uart9_rx.sv
// Directed bench for uart9_rx: one task per scenario.
module sim_uart9_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       sm2 = 1'b0;
    logic       ri_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rb8;
    logic       ri;
    logic [1:0] div = 2'd0;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // Oversampling enable every fourth clock.
    always @(posedge clk) begin
        div    <= div + 2'd1;
        tick16 <= (div == 2'd2);
    end

    uart9_rx u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
        .sm2(sm2), .ri_clr(ri_clr), .rx_data(rx_data), .rb8(rb8), .ri(ri)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            while (!tick16) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b9);
        rxd = 1'b0; wait_ticks(16);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i]; wait_ticks(16);
        end
        rxd = b9;   wait_ticks(16);
        rxd = 1'b1; wait_ticks(16);
    endtask

    task automatic pulse_clear();
        @(negedge clk); ri_clr = 1'b1;
        @(negedge clk); ri_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 ri", {8'h0, ri}, 9'h0);
        check("R1 rx_data", {1'b0, rx_data}, 9'h0);
        check("R1 rb8", {8'h0, rb8}, 9'h0);
    endtask

    task automatic t_plain();
        sm2 = 1'b0;
        send_frame(8'h4B, 1'b0); wait_ticks(4);
        check("R5 ri", {8'h0, ri}, 9'h1);
        check("R4 rx_data lsb first", {1'b0, rx_data}, 9'h04B);
        check("R5 rb8", {8'h0, rb8}, 9'h0);
    endtask

    task automatic t_blocked();
        send_frame(8'h3C, 1'b1); wait_ticks(4);
        check("R6 rx_data held", {1'b0, rx_data}, 9'h04B);
        check("R6 rb8 held", {8'h0, rb8}, 9'h0);
        check("R6 ri held", {8'h0, ri}, 9'h1);
    endtask

    task automatic t_clear();
        wait_ticks(3);
        check("R8 ri kept without pulse", {8'h0, ri}, 9'h1);
        pulse_clear();
        check("R8 ri cleared", {8'h0, ri}, 9'h0);
    endtask

    task automatic t_filter();
        sm2 = 1'b1;
        send_frame(8'h77, 1'b0); wait_ticks(4);
        check("R7 ri stays low", {8'h0, ri}, 9'h0);
        check("R7 rx_data held", {1'b0, rx_data}, 9'h04B);
        send_frame(8'h81, 1'b1); wait_ticks(4);
        check("R7 address frame ri", {8'h0, ri}, 9'h1);
        check("R7 address frame data", {rb8, rx_data}, 9'h181);
        pulse_clear();
    endtask

    task automatic t_false_start();
        sm2 = 1'b0;
        rxd = 1'b0; wait_ticks(4);
        rxd = 1'b1; wait_ticks(30);
        check("R3 glitch ignored ri", {8'h0, ri}, 9'h0);
        check("R3 glitch ignored data", {rb8, rx_data}, 9'h181);
        send_frame(8'hC6, 1'b0); wait_ticks(4);
        check("R3 resumed after abort", {ri, rx_data}, 9'h1C6);
        pulse_clear();
    endtask

    task automatic t_back_to_back();
        sm2 = 1'b1;
        send_frame(8'h12, 1'b0);
        send_frame(8'hE5, 1'b1); wait_ticks(4);
        check("R9 second frame ri", {8'h0, ri}, 9'h1);
        check("R9 second frame data", {rb8, rx_data}, 9'h1E5);
        pulse_clear();
    endtask

    task automatic t_disabled();
        sm2 = 1'b0;
        rx_en = 1'b0;
        send_frame(8'h5A, 1'b1); wait_ticks(4);
        check("R10 disabled ri", {8'h0, ri}, 9'h0);
        check("R10 disabled data", {rb8, rx_data}, 9'h1E5);
        rx_en = 1'b1;
        wait_ticks(4);
        check("R2 enabled again", {8'h0, ri}, 9'h0);
        send_frame(8'h2D, 1'b0); wait_ticks(4);
        check("R2 frame after enable", {rb8, rx_data}, 9'h02D);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        rx_en = 1'b1;
        wait_ticks(4);
        t_plain();
        t_blocked();
        t_clear();
        t_filter();
        t_false_start();
        t_back_to_back();
        t_disabled();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule